// File: doc/BRIEF.md
# Pause Flow-Control Timer Unit

This block keeps the two 16-bit pause timers that an Ethernet MAC needs for full-duplex flow control. One timer, on the receive side, sets the pace of outgoing pause frames while the local receiver is congested. It asks the transmit path for a pause frame. When that frame has gone out, the timer loads a value a little below the advertised pause time and counts down once per slot time. When it reaches zero and congestion still holds, the timer asks for the next pause frame. Because the reload sits below the advertised value, each fresh pause frame leaves before the link partner's pause runs out.

The other timer, on the transmit side, takes the pause time carried by a pause frame from the partner. While that timer is nonzero, the block holds off the start of new frames. A frame already on the wire is never aborted, because the gate only governs when the next frame starts. Both timers are visible as read-only status. Both change only on the slot-time pulse, except when they are loaded, and a load takes priority over a decrement in the same cycle.

Top module: `pause_flow_ctl`

## Requirements
- R1: After synchronous reset, both timer outputs are 0, `pause_req` is 0 and `tx_enable` is 1.
- R2: A `pause_rcvd` pulse loads `tx_timer` with `pause_rcvd_quanta`, visible the cycle after the pulse. `tx_enable` is 0 whenever `tx_timer` is nonzero.
- R3: Each `slot_tick` pulse lowers a nonzero timer by exactly one. A timer at 0 stays at 0 and never wraps. `tx_enable` returns to 1 when `tx_timer` reaches 0.
- R4: When a load and a `slot_tick` happen in the same cycle, the timer takes the loaded value with no decrement.
- R5: A received pause time of 0 sets `tx_timer` to 0 and leaves `tx_enable` at 1.
- R6: When the receive side is idle, with `rx_timer` at 0 and no outstanding request, asserting `congest` raises `pause_req` in the next cycle. `pause_req` then stays high until a `pause_sent` pulse, even if `congest` drops.
- R7: A `pause_sent` pulse while `pause_req` is high loads `rx_timer` with `pause_sent_quanta` minus 0x00FF, saturating at 0. A sent pause time of 0xFFFF therefore loads 0xFF00. `pause_req` drops in the next cycle.
- R8: If `congest` is high when `rx_timer` has counted down to 0, `pause_req` rises one cycle after the timer reads 0.
- R9: If `congest` is low when `rx_timer` reaches 0, no new request is made and `rx_timer` stays at 0.
- R10: A `pause_sent` pulse while `pause_req` is low changes neither `rx_timer` nor `pause_req`.
- R11: Without a `slot_tick` or a load, neither timer changes value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick | input | 1 | One-cycle pulse per slot time |
| congest | input | 1 | Local receiver requests flow control |
| pause_sent | input | 1 | Strobe: requested pause frame has been transmitted |
| pause_sent_quanta | input | 16 | Pause time carried by the transmitted frame |
| pause_rcvd | input | 1 | Strobe: pause frame received from the partner |
| pause_rcvd_quanta | input | 16 | Pause time field of the received frame |
| pause_req | output | 1 | Request to transmit a pause frame |
| tx_enable | output | 1 | High when a new frame may start |
| rx_timer | output | 16 | Receive-side pause timer value |
| tx_timer | output | 16 | Transmit-side pause timer value |

## Verification
The bench runs the full 0xFF00-tick countdown and checks that the re-request comes exactly one cycle after the timer reads 0. A design that compared against 1, or that wrapped through 0xFFFF, would show up here as an early request or a missing one. The bench also sends load and tick in the same cycle on both timers, which exposes a design that decrements the freshly loaded value. It uses sent pause times below 0x00FF to catch a reload that wraps instead of saturating. It uses received pause times of 0 to catch a gate that stays closed for a cycle. Stray send strobes with no request outstanding, and a congestion drop while a request is pending, show whether the request is held correctly and whether stray strobes are ignored.

// File: rtl/pause_pkg.sv
package pause_pkg;

    localparam int unsigned QUANTA_W = 16;

    typedef logic [QUANTA_W-1:0] quanta_t;

    // Margin subtracted from the advertised pause time on reload
    localparam quanta_t RELOAD_MARGIN = quanta_t'(16'h00FF);

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_REQ  = 2'd1,
        RX_WAIT = 2'd2
    } rx_state_e;

    function automatic quanta_t reload_from_sent(input quanta_t sent);
        if (sent > RELOAD_MARGIN)
            return quanta_t'(sent - RELOAD_MARGIN);
        else
            return '0;
    endfunction

endpackage

// File: rtl/pause_down_counter.sv
module pause_down_counter #(
    parameter int unsigned W = pause_pkg::QUANTA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic [W-1:0] value,
    output logic         is_zero
);

    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (load)
            value <= load_val;
        else if (tick && (value != '0))
            value <= value - W'(1);
    end

    assign is_zero = (value == '0);

    a_r4_load_wins: assert property (@(posedge clk) disable iff (rst)
        load |=> (value == $past(load_val)));

    a_r3_dec_one: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && (value != '0)) |=> (value == $past(value) - W'(1)));

    a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && (value == '0)) |=> (value == '0));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(value));

endmodule

// File: rtl/pause_rx_pacer.sv
module pause_rx_pacer
    import pause_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    slot_tick,
    input  logic    congest,
    input  logic    pause_sent,
    input  quanta_t sent_quanta,
    output logic    pause_req,
    output quanta_t rx_timer
);

    rx_state_e state_q, state_d;
    logic      timer_zero;
    logic      do_load;

    assign do_load = (state_q == RX_REQ) && pause_sent;

    pause_down_counter #(.W(QUANTA_W)) u_rx_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (do_load),
        .load_val (reload_from_sent(sent_quanta)),
        .tick     (slot_tick),
        .value    (rx_timer),
        .is_zero  (timer_zero)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (congest) state_d = RX_REQ;
            RX_REQ:  if (pause_sent) state_d = RX_WAIT;
            RX_WAIT: if (timer_zero) state_d = congest ? RX_REQ : RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RX_IDLE;
        else     state_q <= state_d;
    end

    assign pause_req = (state_q == RX_REQ);

    a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
        (pause_req && !pause_sent) |=> pause_req);

    a_r7_reload: assert property (@(posedge clk) disable iff (rst)
        (pause_req && pause_sent) |=>
            (!pause_req && (rx_timer == reload_from_sent($past(sent_quanta)))));

    a_r10_stray_sent: assert property (@(posedge clk) disable iff (rst)
        (!pause_req && pause_sent && !slot_tick) |=> $stable(rx_timer));

    a_r9_no_rerequest: assert property (@(posedge clk) disable iff (rst)
        ((state_q == RX_WAIT) && (rx_timer == '0) && !congest) |=> !pause_req);

    a_r8_rerequest: assert property (@(posedge clk) disable iff (rst)
        ((state_q == RX_WAIT) && (rx_timer == '0) && congest) |=> pause_req);

endmodule

// File: rtl/pause_tx_gate.sv
module pause_tx_gate
    import pause_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    slot_tick,
    input  logic    pause_rcvd,
    input  quanta_t rcvd_quanta,
    output logic    tx_enable,
    output quanta_t tx_timer
);

    logic timer_zero;

    pause_down_counter #(.W(QUANTA_W)) u_tx_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (pause_rcvd),
        .load_val (rcvd_quanta),
        .tick     (slot_tick),
        .value    (tx_timer),
        .is_zero  (timer_zero)
    );

    assign tx_enable = timer_zero;

    a_r2_gate_closes: assert property (@(posedge clk) disable iff (rst)
        (pause_rcvd && (rcvd_quanta != '0)) |=> !tx_enable);

    a_r5_zero_quanta: assert property (@(posedge clk) disable iff (rst)
        (pause_rcvd && (rcvd_quanta == '0)) |=> tx_enable);

    a_r3_reopen: assert property (@(posedge clk) disable iff (rst)
        (!pause_rcvd && slot_tick && (tx_timer == quanta_t'(1))) |=> tx_enable);

endmodule

// File: rtl/pause_flow_ctl.sv
module pause_flow_ctl
    import pause_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                slot_tick,
    input  logic                congest,
    input  logic                pause_sent,
    input  logic [QUANTA_W-1:0] pause_sent_quanta,
    input  logic                pause_rcvd,
    input  logic [QUANTA_W-1:0] pause_rcvd_quanta,
    output logic                pause_req,
    output logic                tx_enable,
    output logic [QUANTA_W-1:0] rx_timer,
    output logic [QUANTA_W-1:0] tx_timer
);

    pause_rx_pacer u_rx (
        .clk         (clk),
        .rst         (rst),
        .slot_tick   (slot_tick),
        .congest     (congest),
        .pause_sent  (pause_sent),
        .sent_quanta (pause_sent_quanta),
        .pause_req   (pause_req),
        .rx_timer    (rx_timer)
    );

    pause_tx_gate u_tx (
        .clk         (clk),
        .rst         (rst),
        .slot_tick   (slot_tick),
        .pause_rcvd  (pause_rcvd),
        .rcvd_quanta (pause_rcvd_quanta),
        .tx_enable   (tx_enable),
        .tx_timer    (tx_timer)
    );

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!pause_req && tx_enable && (rx_timer == '0) && (tx_timer == '0)));

endmodule

// File: tb/test_pause_flow_ctl.sv
module test_pause_flow_ctl;

    logic        clk = 1'b0;
    logic        rst;
    logic        slot_tick;
    logic        congest;
    logic        pause_sent;
    logic [15:0] pause_sent_quanta;
    logic        pause_rcvd;
    logic [15:0] pause_rcvd_quanta;
    logic        pause_req;
    logic        tx_enable;
    logic [15:0] rx_timer;
    logic [15:0] tx_timer;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    pause_flow_ctl i_pause_flow_ctl (
        .clk               (clk),
        .rst               (rst),
        .slot_tick         (slot_tick),
        .congest           (congest),
        .pause_sent        (pause_sent),
        .pause_sent_quanta (pause_sent_quanta),
        .pause_rcvd        (pause_rcvd),
        .pause_rcvd_quanta (pause_rcvd_quanta),
        .pause_req         (pause_req),
        .tx_enable         (tx_enable),
        .rx_timer          (rx_timer),
        .tx_timer          (tx_timer)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick_once();
        @(negedge clk) slot_tick = 1'b1;
        @(negedge clk) slot_tick = 1'b0;
    endtask

    task automatic test_reset();
        rst = 1'b1; slot_tick = 0; congest = 0; pause_sent = 0; pause_rcvd = 0;
        pause_sent_quanta = '0; pause_rcvd_quanta = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rx_timer", rx_timer, 0);
        chk("R1 tx_timer", tx_timer, 0);
        chk("R1 pause_req", pause_req, 0);
        chk("R1 tx_enable", tx_enable, 1);
    endtask

    task automatic test_tx_countdown();
        pause_rcvd = 1; pause_rcvd_quanta = 16'd3;
        @(negedge clk) pause_rcvd = 0;
        chk("R2 tx_timer load", tx_timer, 3);
        chk("R2 tx_enable low", tx_enable, 0);
        repeat (4) @(negedge clk);
        chk("R11 tx_timer holds", tx_timer, 3);
        tick_once(); chk("R3 tx dec 2", tx_timer, 2);
        chk("R3 still gated", tx_enable, 0);
        tick_once(); chk("R3 tx dec 1", tx_timer, 1);
        tick_once(); chk("R3 tx reaches 0", tx_timer, 0);
        chk("R3 tx_enable reopens", tx_enable, 1);
        tick_once(); chk("R3 no wrap", tx_timer, 0);
    endtask

    task automatic test_tx_corner();
        pause_rcvd = 1; pause_rcvd_quanta = 16'd5; slot_tick = 1;
        @(negedge clk) pause_rcvd = 0; slot_tick = 0;
        chk("R4 tx load beats tick", tx_timer, 5);
        pause_rcvd = 1; pause_rcvd_quanta = 16'hFFFF;
        @(negedge clk) pause_rcvd = 0;
        chk("R2 tx full quanta", tx_timer, 16'hFFFF);
        pause_rcvd = 1; pause_rcvd_quanta = 16'd0;
        @(negedge clk) pause_rcvd = 0;
        chk("R5 zero quanta timer", tx_timer, 0);
        chk("R5 zero quanta enable", tx_enable, 1);
    endtask

    task automatic test_rx_full_cycle();
        congest = 1;
        @(negedge clk);
        chk("R6 req rises", pause_req, 1);
        repeat (3) @(negedge clk);
        chk("R6 req held", pause_req, 1);
        pause_sent = 1; pause_sent_quanta = 16'hFFFF;
        @(negedge clk) pause_sent = 0;
        chk("R7 reload FF00", rx_timer, 16'hFF00);
        chk("R7 req drops", pause_req, 0);
        slot_tick = 1;
        repeat (16'hFF00) @(negedge clk);
        slot_tick = 0;
        chk("R8 rx at zero", rx_timer, 0);
        chk("R8 no early req", pause_req, 0);
        @(negedge clk);
        chk("R8 re-request", pause_req, 1);
    endtask

    task automatic test_rx_release();
        pause_sent = 1; pause_sent_quanta = 16'h0103; slot_tick = 1;
        @(negedge clk) pause_sent = 0; slot_tick = 0;
        chk("R4 rx load beats tick", rx_timer, 4);
        chk("R7 req cleared", pause_req, 0);
        congest = 0;
        repeat (4) tick_once();
        chk("R9 rx reached 0", rx_timer, 0);
        repeat (3) @(negedge clk);
        chk("R9 no new req", pause_req, 0);
        tick_once();
        chk("R9 rx stays 0", rx_timer, 0);
    endtask

    task automatic test_rx_small_and_stray();
        congest = 1;
        @(negedge clk);
        chk("R6 req again", pause_req, 1);
        pause_sent = 1; pause_sent_quanta = 16'h0050;
        @(negedge clk) pause_sent = 0;
        chk("R7 saturate to 0", rx_timer, 0);
        chk("R7 req low after send", pause_req, 0);
        @(negedge clk);
        chk("R8 immediate re-request", pause_req, 1);
        congest = 0;
        repeat (3) @(negedge clk);
        chk("R6 held after congest drop", pause_req, 1);
        pause_sent = 1; pause_sent_quanta = 16'h0200;
        @(negedge clk) pause_sent = 0;
        chk("R7 reload 0101", rx_timer, 16'h0101);
        pause_sent = 1; pause_sent_quanta = 16'h1234;
        @(negedge clk) pause_sent = 0;
        chk("R10 stray send timer", rx_timer, 16'h0101);
        chk("R10 stray send req", pause_req, 0);
    endtask

    initial begin
        #1_500_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_tx_countdown();
        test_tx_corner();
        test_rx_full_cycle();
        test_rx_release();
        test_rx_small_and_stray();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule